// File: doc/BRIEF.md
# Register-Mapped GPIO Port Unit

This block gives a small microcontroller data bus access to three I/O ports through byte-wide registers. The first port is input only. The second port has eight bidirectional pins. The third port has two bidirectional pins and two storage bits with no pin: one drives an oscillator low-power control and the other a display power enable. Each bidirectional pin has a direction bit. A 1 floats the driver so the pin acts as an input. A 0 drives the pin from its output latch.

The block decodes byte addresses combinationally. Every pin passes through a two-flop synchronizer, and reads return the synchronized live pin level rather than a stored copy. Software performs bit set, bit clear and complement as read-modify-write: it reads the port, changes a bit and writes the whole byte back. Falling edges on input-port lines raise a one-cycle wake request for each line enabled in a mask. A falling edge on the top input line also raises a battery-event pulse.

Top module: `gpio_port_unit`

## Requirements
- R1: After reset, every direction bit and every latch bit is 1. pb_oe_o=00h, pb_data_o=FFh, pc_oe_o=0, pc_data_o=3, osc_lp_o=1 and lcd_pwr_o=1. A read of 15h returns FFh and a read of 17h returns 03h.
- R2: A write to 14h loads the eight output latches of the bidirectional port, seen on pb_data_o after the next rising edge. The latch then holds until the next write to 14h.
- R3: Bit i of 15h (17h bits 1:0 for the small port) sets the direction of pin i. With 0, pb_oe_o[i]/pc_oe_o[i] is 1 and the pin is driven. With 1, the output enable is 0. Reads of 15h/17h return the stored bits.
- R4: Reads of 12h and 14h return pin levels through a two-flop synchronizer. A pin change made before a rising edge is visible to reads after the second edge that follows. The latch contents are not returned.
- R5: At 16h, bits 1:0 read the small-port pins through the synchronizer, bit 2 reads the oscillator control latch and bit 3 reads the display power latch. A write sets those latches, and osc_lp_o/lcd_pwr_o follow them after the next edge. Bits 7:4 read 0 and writes to them have no effect.
- R6: At 17h only bits 1:0 exist. Bits 7:2 read 0 and writes to them are ignored.
- R7: rdata_o is 0 whenever rd_en_i is 0 or the address is not one of 12h, 14h, 15h, 16h, 17h. Writes to other addresses, including the read-only 12h, change no output or register.
- R8: wake_o pulses for exactly one clock for each synchronized falling edge on an input-port line whose wake_mask_i bit is 1. Edges on masked-off lines produce no pulse.
- R9: batt_irq_o pulses for one clock on each synchronized falling edge of input-port bit 7, independent of wake_mask_i.
- R10: On a pin set as output, a read returns the driven level. So a read, a single-bit change and a write-back of 14h alters only that bit of pb_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| pa_pad_i | input | 8 | Input-only port pins |
| wake_mask_i | input | 8 | Per-line wake enable for the input port |
| wake_o | output | 1 | Wake request pulse |
| batt_irq_o | output | 1 | Battery-event pulse |
| pb_pad_i | input | 8 | Bidirectional port pin levels |
| pb_data_o | output | 8 | Bidirectional port output latch |
| pb_oe_o | output | 8 | Bidirectional port output enables |
| pc_pad_i | input | 2 | Small port pin levels |
| pc_data_o | output | 2 | Small port output latch |
| pc_oe_o | output | 2 | Small port output enables |
| osc_lp_o | output | 1 | Oscillator low-power control (0 = active) |
| lcd_pwr_o | output | 1 | Display power enable (1 = on) |

## Verification
The bench builds the block with its default parameters: eight input lines, eight bidirectional pins, two small-port pins and two synchronizer stages. With these values every decoded address and the top input line used for the battery event match the register layout the requirements describe. The two-stage synchronizer places pin-to-read latency and wake pulses in a short, fixed window, so exact sampling points can be predicted. Random direction, latch and pin patterns exercise driven and floating pins together. This covers the read-modify-write case where read data has to come from the driven pad.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] ADDR_PA  = 8'h12;
  localparam logic [DW-1:0] ADDR_PB  = 8'h14;
  localparam logic [DW-1:0] ADDR_PBD = 8'h15;
  localparam logic [DW-1:0] ADDR_PC  = 8'h16;
  localparam logic [DW-1:0] ADDR_PCD = 8'h17;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_fall_det.sv
module gpio_fall_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else prev_q <= d_i;
  end

  assign fall_o = prev_q & ~d_i;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned LAT_W = 8,
  parameter int unsigned DIR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lat_we_i,
  input  logic [LAT_W-1:0] lat_d_i,
  input  logic             dir_we_i,
  input  logic [DIR_W-1:0] dir_d_i,
  output logic [LAT_W-1:0] lat_o,
  output logic [DIR_W-1:0] dir_o
);
  // all ones at reset: pins float as inputs, latches high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_o <= '1;
      dir_o <= '1;
    end else begin
      if (lat_we_i) lat_o <= lat_d_i;
      if (dir_we_i) dir_o <= dir_d_i;
    end
  end
endmodule

// File: rtl/gpio_port_unit.sv
module gpio_port_unit
  import gpio_port_pkg::*;
#(
  parameter int unsigned PA_W        = 8,
  parameter int unsigned PB_W        = 8,
  parameter int unsigned PC_PINS     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [PA_W-1:0]    pa_pad_i,
  input  logic [PA_W-1:0]    wake_mask_i,
  output logic               wake_o,
  output logic               batt_irq_o,
  input  logic [PB_W-1:0]    pb_pad_i,
  output logic [PB_W-1:0]    pb_data_o,
  output logic [PB_W-1:0]    pb_oe_o,
  input  logic [PC_PINS-1:0] pc_pad_i,
  output logic [PC_PINS-1:0] pc_data_o,
  output logic [PC_PINS-1:0] pc_oe_o,
  output logic               osc_lp_o,
  output logic               lcd_pwr_o
);
  localparam int unsigned PC_LAT_W = PC_PINS + 2;
  localparam int unsigned SYNC_W   = PA_W + PB_W + PC_PINS;
  localparam int unsigned OSC_BIT  = PC_PINS;
  localparam int unsigned LCD_BIT  = PC_PINS + 1;

  logic [SYNC_W-1:0]   sync_q;
  logic [PA_W-1:0]     pa_s, pa_fall;
  logic [PB_W-1:0]     pb_s, pb_lat, pb_dir;
  logic [PC_PINS-1:0]  pc_s, pc_dir;
  logic [PC_LAT_W-1:0] pc_lat;

  gpio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pc_pad_i, pb_pad_i, pa_pad_i}),
    .q_o   (sync_q)
  );

  assign pa_s = sync_q[PA_W-1:0];
  assign pb_s = sync_q[PA_W +: PB_W];
  assign pc_s = sync_q[PA_W+PB_W +: PC_PINS];

  gpio_fall_det #(.W(PA_W)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pa_s),
    .fall_o(pa_fall)
  );

  assign wake_o     = |(pa_fall & wake_mask_i);
  assign batt_irq_o = pa_fall[PA_W-1];

  gpio_port_regs #(.LAT_W(PB_W), .DIR_W(PB_W)) u_pb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lat_we_i(wr_en_i && addr_i == ADDR_PB),
    .lat_d_i (wdata_i[PB_W-1:0]),
    .dir_we_i(wr_en_i && addr_i == ADDR_PBD),
    .dir_d_i (wdata_i[PB_W-1:0]),
    .lat_o   (pb_lat),
    .dir_o   (pb_dir)
  );

  gpio_port_regs #(.LAT_W(PC_LAT_W), .DIR_W(PC_PINS)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lat_we_i(wr_en_i && addr_i == ADDR_PC),
    .lat_d_i (wdata_i[PC_LAT_W-1:0]),
    .dir_we_i(wr_en_i && addr_i == ADDR_PCD),
    .dir_d_i (wdata_i[PC_PINS-1:0]),
    .lat_o   (pc_lat),
    .dir_o   (pc_dir)
  );

  assign pb_data_o = pb_lat;
  assign pb_oe_o   = ~pb_dir;
  assign pc_data_o = pc_lat[PC_PINS-1:0];
  assign pc_oe_o   = ~pc_dir;
  assign osc_lp_o  = pc_lat[OSC_BIT];
  assign lcd_pwr_o = pc_lat[LCD_BIT];

  // pin bits read live; internal control bits read their latch
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        ADDR_PA:  rdata_o[PA_W-1:0]    = pa_s;
        ADDR_PB:  rdata_o[PB_W-1:0]    = pb_s;
        ADDR_PBD: rdata_o[PB_W-1:0]    = pb_dir;
        ADDR_PC:  rdata_o[PC_LAT_W-1:0] = {pc_lat[LCD_BIT:OSC_BIT], pc_s};
        ADDR_PCD: rdata_o[PC_PINS-1:0] = pc_dir;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_unit_chk.sv
module gpio_port_unit_chk
  import gpio_port_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rdata_o,
  input logic          batt_irq_o,
  input logic [7:0]    pb_data_o,
  input logic [7:0]    pb_oe_o,
  input logic          osc_lp_o,
  input logic          lcd_pwr_o
);
  logic mapped;
  assign mapped = addr_i inside {ADDR_PA, ADDR_PB, ADDR_PBD, ADDR_PC, ADDR_PCD};

  a_r2_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_PB) |=> pb_data_o == $past(wdata_i));

  a_r2_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_PB) |=> $stable(pb_data_o));

  a_r3_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_PBD) |=> pb_oe_o == ~$past(wdata_i));

  a_r5_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_PC) |=>
      (osc_lp_o == $past(wdata_i[2]) && lcd_pwr_o == $past(wdata_i[3])));

  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_PC) |-> rdata_o[7:4] == 4'h0);

  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_PCD) |-> rdata_o[7:2] == 6'h0);

  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || !mapped) |-> rdata_o == '0);

  a_r9_batt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_irq_o |=> !batt_irq_o);
endmodule

bind gpio_port_unit gpio_port_unit_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .batt_irq_o(batt_irq_o),
  .pb_data_o (pb_data_o),
  .pb_oe_o   (pb_oe_o),
  .osc_lp_o  (osc_lp_o),
  .lcd_pwr_o (lcd_pwr_o)
);

// File: tb/gpio_port_unit_tb_top.sv
module gpio_port_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] pa_pad_i = 8'hFF, wake_mask_i = '0;
  logic       wake_o, batt_irq_o;
  logic [7:0] pb_ext = 8'hFF, pb_pad, pb_data_o, pb_oe_o;
  logic [1:0] pc_ext = 2'b11, pc_pad, pc_data_o, pc_oe_o;
  logic       osc_lp_o, lcd_pwr_o;

  int checks = 0, failures = 0;
  int wake_cnt = 0, batt_cnt = 0;
  logic [7:0] m_lat, m_dir;

  always #5 clk_i = ~clk_i;

  // pad model: driven pins show the latch, floating pins the external level
  assign pb_pad = (pb_oe_o & pb_data_o) | (~pb_oe_o & pb_ext);
  assign pc_pad = (pc_oe_o & pc_data_o) | (~pc_oe_o & pc_ext);

  gpio_port_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .pa_pad_i(pa_pad_i), .wake_mask_i(wake_mask_i), .wake_o(wake_o),
    .batt_irq_o(batt_irq_o), .pb_pad_i(pb_pad), .pb_data_o(pb_data_o),
    .pb_oe_o(pb_oe_o), .pc_pad_i(pc_pad), .pc_data_o(pc_data_o),
    .pc_oe_o(pc_oe_o), .osc_lp_o(osc_lp_o), .lcd_pwr_o(lcd_pwr_o)
  );

  always @(negedge clk_i) begin
    if (wake_o) wake_cnt++;
    if (batt_irq_o) batt_cnt++;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    rd_en_i = 1'b0; addr_i = '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk_i);
  endtask

  function automatic logic [7:0] exp_pin(input logic [7:0] lat, input logic [7:0] dir,
                                         input logic [7:0] ext);
    return (~dir & lat) | (dir & ext);
  endfunction

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    chk("R1 pb_data", pb_data_o, 8'hFF);
    chk("R1 pc_oe/data", {4'h0, pc_oe_o, pc_data_o}, 8'h03);
    chk("R1 osc/lcd", {6'h0, osc_lp_o, lcd_pwr_o}, 8'h03);
    rd(8'h15, v); chk("R1 dir15", v, 8'hFF);
    rd(8'h17, v); chk("R1 dir17", v, 8'h03);

    // R2/R3/R4 random patterns on the bidirectional port
    m_lat = 8'hFF; m_dir = 8'hFF;
    for (int i = 0; i < 40; i++) begin
      m_lat = 8'($urandom); m_dir = 8'($urandom);
      pb_ext = 8'($urandom); pa_pad_i = 8'($urandom) | 8'h80;
      wr(8'h14, m_lat); wr(8'h15, m_dir);
      chk("R2 latch", pb_data_o, m_lat);
      chk("R3 oe", pb_oe_o, ~m_dir);
      settle();
      rd(8'h14, v); chk("R4 pb live read", v, exp_pin(m_lat, m_dir, pb_ext));
      rd(8'h12, v); chk("R4 pa read", v, pa_pad_i);
      rd(8'h15, v); chk("R3 dir read", v, m_dir);
    end

    // R4 latch not returned when floating
    wr(8'h15, 8'hFF); wr(8'h14, 8'h00); pb_ext = 8'hA5; settle();
    rd(8'h14, v); chk("R4 floating reads pin", v, 8'hA5);

    // R10 read-modify-write with outputs
    wr(8'h14, 8'h3C); wr(8'h15, 8'h00); pb_ext = 8'hFF; settle();
    rd(8'h14, v); chk("R10 read driven", v, 8'h3C);
    wr(8'h14, v | 8'h01);
    chk("R10 set bit", pb_data_o, 8'h3D);
    settle(); rd(8'h14, v);
    wr(8'h14, v & ~8'h20);
    chk("R10 clear bit", pb_data_o, 8'h1D);

    // R5 small port
    wr(8'h16, 8'hF2);
    chk("R5 osc", {7'h0, osc_lp_o}, 8'h00);
    chk("R5 lcd", {7'h0, lcd_pwr_o}, 8'h00);
    chk("R5 pc latch", {6'h0, pc_data_o}, 8'h02);
    pc_ext = 2'b01; settle();
    rd(8'h16, v); chk("R5 read floating", v, 8'h01);
    wr(8'h16, 8'h08); pc_ext = 2'b11; settle();
    rd(8'h16, v); chk("R5 upper zero, lcd latch", v, 8'h0B);

    // R6 direction of small port
    wr(8'h17, 8'hFE);
    chk("R6 pc_oe", {6'h0, pc_oe_o}, 8'h01);
    rd(8'h17, v); chk("R6 read", v, 8'h02);
    settle(); rd(8'h16, v); chk("R6 driven pin read", v, 8'h0A);

    // R7 unmapped and rd_en low
    wr(8'h13, 8'h00); wr(8'h12, 8'h00); wr(8'h18, 8'h00);
    chk("R7 pb unaffected", pb_data_o, 8'h1D);
    chk("R7 oe unaffected", pb_oe_o, 8'hFF);
    rd(8'h13, v); chk("R7 unmapped read", v, 8'h00);
    rd(8'h80, v); chk("R7 unmapped read", v, 8'h00);
    @(negedge clk_i); addr_i = 8'h14; #1 chk("R7 rd_en low", rdata_o, 8'h00); addr_i = '0;

    // R8/R9 wake and battery pulses
    pa_pad_i = 8'hFF; wake_mask_i = 8'h01; settle(); settle();
    wake_cnt = 0; batt_cnt = 0;
    @(negedge clk_i); pa_pad_i = 8'hFE; settle(); settle();
    chk("R8 enabled edge one pulse", 8'(wake_cnt), 8'd1);
    wake_cnt = 0;
    @(negedge clk_i); pa_pad_i = 8'hFC; settle(); settle();
    chk("R8 masked edge no pulse", 8'(wake_cnt), 8'd0);
    chk("R9 no batt on other lines", 8'(batt_cnt), 8'd0);
    pa_pad_i = 8'hFF; settle(); settle(); wake_cnt = 0;
    @(negedge clk_i); pa_pad_i = 8'h7F; settle(); settle();
    chk("R9 batt pulse unmasked", 8'(batt_cnt), 8'd1);
    chk("R8 bit7 masked no wake", 8'(wake_cnt), 8'd0);
    pa_pad_i = 8'hFF; wake_mask_i = 8'hFF; settle(); settle();
    wake_cnt = 0; batt_cnt = 0;
    @(negedge clk_i); pa_pad_i = 8'h7F; settle(); settle();
    chk("R8 bit7 enabled wake", 8'(wake_cnt), 8'd1);
    chk("R9 batt again", 8'(batt_cnt), 8'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule